// File: doc/BRIEF.md
# Ethernet Transmit Inter-Packet Gap Controller

This block sits beside the transmit side of an Ethernet MAC that moves one nibble per clock on an MII-style path. It watches the MAC's transmit enable, and when a frame ends it drops a transmit-permit output. It raises the output again once a programmed number of idle nibble times has gone by. The MAC may start a new frame in any cycle in which the permit output is high.

Two gap lengths are kept. A back-to-back gap applies when another frame is already waiting on the first idle nibble. Its programmed value carries a bias that depends on the duplex select. A non-back-to-back gap applies when nothing is waiting at that moment. In half duplex this second gap restarts for as long as carrier is seen on the wire. Both values are written through a small host write port. The gap length, its kind and the duplex handling are fixed when a gap begins, so writes and duplex changes made during a gap apply only to the next one.

Top module: `ipg_ctrl`

## Requirements
- R1: After reset `tx_permit` is 1. The back-to-back register holds 0x15 and the non-back-to-back register holds 0x12, so the first gaps last 27 nibbles for back-to-back in half duplex, 24 for back-to-back in full duplex, and 24 for non-back-to-back.
- R2: `tx_permit` is 0 in every cycle after a cycle with `tx_en` = 1. After the last frame nibble (cycle T) it stays 0 for exactly G cycles (T+1 to T+G) and returns to 1 in cycle T+G+1. G is the gap length below.
- R3: For a back-to-back gap in half duplex (`duplex_full` = 0), G equals the back-to-back register plus 6.
- R4: For a back-to-back gap in full duplex (`duplex_full` = 1), G equals the back-to-back register plus 3.
- R5: The gap is back-to-back if `frame_req` is 1 in cycle T+1. Otherwise it is non-back-to-back, and a request that arrives later in that gap does not change its length.
- R6: For a non-back-to-back gap, G equals the register value plus 6. Half duplex uses the whole register. Full duplex uses only its low 8 bits.
- R7: During a non-back-to-back gap in half duplex, each cycle with `crs` = 1 restarts the gap. `tx_permit` returns to 1 only after G cycles in a row with `crs` = 0.
- R8: `crs` has no effect in full duplex, and no effect during back-to-back gaps.
- R9: A register write (`cfg_we` = 1, with `cfg_sel` 0 selecting the back-to-back register and 1 selecting the non-back-to-back register) or a change of `duplex_full` made during a gap leaves that gap's length unchanged. The next gap uses the new setting.
- R10: While no gap is running and `tx_en` is 0, `tx_permit` stays 1 whatever the values of `frame_req` and `crs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duplex_full | input | 1 | 1 for full duplex, 0 for half duplex |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 1 | 0 selects the back-to-back register, 1 the non-back-to-back register |
| cfg_wdata | input | NB_W | Write data (the back-to-back register takes the low B2B_W bits) |
| tx_en | input | 1 | MAC transmit enable, 1 on every frame nibble |
| frame_req | input | 1 | A further frame is queued |
| crs | input | 1 | Carrier sense from the PHY |
| tx_permit | output | 1 | The MAC may begin a frame in this cycle |

## Verification
The hardest situations to reach from the ports are the ones in the middle of a gap. These are carrier appearing at a chosen idle nibble, a request arriving after the gap kind is already fixed, and a register write or duplex change landing while a gap is counting. The bench's measurement routine numbers each idle nibble after the frame ends. It can raise carrier, a request, a write or a duplex flip at any chosen index. It then counts the low-permit cycles and compares the count with a value worked out from the register contents, the latched duplex and the last carrier cycle.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

    // Nibble-time bias added to the programmed values
    localparam int HALF_B2B_BIAS = 6;
    localparam int FULL_B2B_BIAS = 3;
    localparam int NB_BIAS       = 6;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_TX   = 2'd1,
        GS_GAP  = 2'd2
    } gap_state_e;

    localparam logic CFG_SEL_B2B = 1'b0;
    localparam logic CFG_SEL_NB  = 1'b1;

endpackage

// File: rtl/ipg_cfg_regs.sv
module ipg_cfg_regs #(
    parameter int B2B_W   = 7,
    parameter int NB_W    = 12,
    parameter int B2B_RST = 'h15,
    parameter int NB_RST  = 'h12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [NB_W-1:0]  cfg_wdata,
    output logic [B2B_W-1:0] b2b_val,
    output logic [NB_W-1:0]  nb_val
);
    import ipg_pkg::*;

    typedef struct packed {
        logic [B2B_W-1:0] b2b;
        logic [NB_W-1:0]  nb;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            if (cfg_sel == CFG_SEL_B2B) begin
                regs_d.b2b = cfg_wdata[B2B_W-1:0];
            end else begin
                regs_d.nb = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.b2b <= B2B_W'(B2B_RST);
            regs_q.nb  <= NB_W'(NB_RST);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign b2b_val = regs_q.b2b;
    assign nb_val  = regs_q.nb;

endmodule

// File: rtl/ipg_gap_calc.sv
module ipg_gap_calc #(
    parameter int B2B_W     = 7,
    parameter int NB_W      = 12,
    parameter int FULL_NB_W = 8,
    parameter int CNT_W     = 13
) (
    input  logic [B2B_W-1:0] b2b_val,
    input  logic [NB_W-1:0]  nb_val,
    input  logic             full,
    input  logic             b2b_sel,
    output logic [CNT_W-1:0] gap_len
);
    import ipg_pkg::*;

    logic [NB_W-1:0] nb_eff_full;

    // Full duplex sees only the low part of the idle-start register
    generate
        if (NB_W > FULL_NB_W) begin : g_trunc
            assign nb_eff_full = {{(NB_W-FULL_NB_W){1'b0}}, nb_val[FULL_NB_W-1:0]};
        end else begin : g_whole
            assign nb_eff_full = nb_val;
        end
    endgenerate

    always_comb begin
        if (b2b_sel) begin
            gap_len = CNT_W'(b2b_val)
                    + (full ? CNT_W'(FULL_B2B_BIAS) : CNT_W'(HALF_B2B_BIAS));
        end else begin
            gap_len = (full ? CNT_W'(nb_eff_full) : CNT_W'(nb_val))
                    + CNT_W'(NB_BIAS);
        end
    end

endmodule

// File: rtl/ipg_gap_timer.sv
module ipg_gap_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             crs,
    input  logic             duplex_full,
    input  logic             b2b_sel,
    input  logic [CNT_W-1:0] gap_len,
    output logic             tx_permit,
    output logic             crs_hold
);
    import ipg_pkg::*;

    typedef struct packed {
        gap_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic             hold;
        logic             permit;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic start_hold;

    assign start_hold = !b2b_sel && !duplex_full;

    always_comb begin
        tmr_d = tmr_q;
        unique case (tmr_q.state)
            GS_IDLE: begin
                if (tx_en) begin
                    tmr_d.state = GS_TX;
                end
            end
            GS_TX: begin
                if (!tx_en) begin
                    // first idle nibble: fix kind, length and carrier handling
                    tmr_d.state = GS_GAP;
                    tmr_d.len   = gap_len;
                    tmr_d.hold  = start_hold;
                    tmr_d.cnt   = (start_hold && crs) ? gap_len : gap_len - CNT_W'(1);
                end
            end
            GS_GAP: begin
                if (tx_en) begin
                    tmr_d.state = GS_TX;
                end else if (tmr_q.hold && crs) begin
                    tmr_d.cnt = tmr_q.len;
                end else if (tmr_q.cnt <= CNT_W'(1)) begin
                    tmr_d.state = GS_IDLE;
                    tmr_d.cnt   = '0;
                end else begin
                    tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                tmr_d.state = GS_IDLE;
            end
        endcase
        tmr_d.permit = (tmr_d.state == GS_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.state  <= GS_IDLE;
            tmr_q.cnt    <= '0;
            tmr_q.len    <= '0;
            tmr_q.hold   <= 1'b0;
            tmr_q.permit <= 1'b1;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign tx_permit = tmr_q.permit;
    assign crs_hold  = (tmr_q.state == GS_GAP) && tmr_q.hold;

endmodule

// File: rtl/ipg_ctrl.sv
module ipg_ctrl #(
    parameter int B2B_W     = 7,
    parameter int NB_W      = 12,
    parameter int FULL_NB_W = 8,
    parameter int B2B_RST   = 'h15,
    parameter int NB_RST    = 'h12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            duplex_full,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [NB_W-1:0] cfg_wdata,
    input  logic            tx_en,
    input  logic            frame_req,
    input  logic            crs,
    output logic            tx_permit
);
    localparam int MAX_GAP = (1 << NB_W) + 8;
    localparam int CNT_W   = $clog2(MAX_GAP + 1);

    logic [B2B_W-1:0] b2b_val;
    logic [NB_W-1:0]  nb_val;
    logic [CNT_W-1:0] gap_len;
    logic             crs_hold;

    ipg_cfg_regs #(
        .B2B_W   (B2B_W),
        .NB_W    (NB_W),
        .B2B_RST (B2B_RST),
        .NB_RST  (NB_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .b2b_val   (b2b_val),
        .nb_val    (nb_val)
    );

    ipg_gap_calc #(
        .B2B_W     (B2B_W),
        .NB_W      (NB_W),
        .FULL_NB_W (FULL_NB_W),
        .CNT_W     (CNT_W)
    ) u_calc (
        .b2b_val (b2b_val),
        .nb_val  (nb_val),
        .full    (duplex_full),
        .b2b_sel (frame_req),
        .gap_len (gap_len)
    );

    ipg_gap_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .crs         (crs),
        .duplex_full (duplex_full),
        .b2b_sel     (frame_req),
        .gap_len     (gap_len),
        .tx_permit   (tx_permit),
        .crs_hold    (crs_hold)
    );

endmodule

// File: rtl/ipg_ctrl_chk.sv
module ipg_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic crs,
    input logic tx_permit,
    input logic crs_hold
);
    logic [3:0] idle_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_run <= '0;
        end else if (tx_en) begin
            idle_run <= '0;
        end else if (idle_run != 4'd15) begin
            idle_run <= idle_run + 4'd1;
        end
    end

    // R2: a transmitting nibble closes the permit for the following cycle
    a_r2_tx_closes: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |=> !tx_permit);

    // R2: the permit never reopens before the smallest possible gap (3 nibbles)
    a_r2_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_permit) |-> (idle_run >= 4'd3));

    // R7: carrier during a held idle-start gap keeps the permit closed
    a_r7_crs_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (crs_hold && crs && !tx_en) |=> !tx_permit);

    // R10: an open permit stays open while nothing transmits
    a_r10_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_permit && !tx_en) |=> tx_permit);

endmodule

bind ipg_ctrl ipg_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .crs       (crs),
    .tx_permit (tx_permit),
    .crs_hold  (crs_hold)
);

// File: tb/tb_ipg_ctrl.sv
module tb_ipg_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        duplex_full = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic        tx_en = 1'b0;
    logic        frame_req = 1'b0;
    logic        crs = 1'b0;
    logic        tx_permit;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    ipg_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .duplex_full (duplex_full),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .tx_en       (tx_en),
        .frame_req   (frame_req),
        .crs         (crs),
        .tx_permit   (tx_permit)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [11:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // act_kind: 0 none, 1 write b2b reg, 2 write nb reg, 3 flip duplex
    task automatic run_gap(input logic b2b, input int crs_from, input int crs_len,
                           input int act_at, input int act_kind,
                           input logic [11:0] act_data, input int req_at,
                           output int n);
        @(negedge clk);
        while (!tx_permit) @(negedge clk);
        frame_req = b2b;
        for (int i = 0; i < 6; i++) begin
            tx_en = 1'b1;
            @(negedge clk);
        end
        n = 0;
        tx_en = 1'b0;
        for (int j = 1; j < 10000; j++) begin
            crs = (crs_len > 0) && (j >= crs_from) && (j < crs_from + crs_len);
            cfg_we = 1'b0;
            if (j == act_at) begin
                if (act_kind == 1) begin cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = act_data; end
                if (act_kind == 2) begin cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = act_data; end
                if (act_kind == 3) duplex_full = ~duplex_full;
            end
            if (j == req_at) frame_req = 1'b1;
            if (tx_permit) break;
            n = n + 1;
            @(negedge clk);
        end
        frame_req = 1'b0; crs = 1'b0; cfg_we = 1'b0;
    endtask

    typedef struct packed {
        logic        full;
        logic        b2b;
        logic [11:0] b2b_val;
        logic [11:0] nb_val;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b0, 1'b1, 12'h012, 12'h012, 16'd24},   // R3
        '{1'b1, 1'b1, 12'h015, 12'h012, 16'd24},   // R4
        '{1'b0, 1'b1, 12'h000, 12'h012, 16'd6},    // R3
        '{1'b1, 1'b1, 12'h000, 12'h012, 16'd3},    // R4
        '{1'b0, 1'b1, 12'h07F, 12'h012, 16'd133},  // R3
        '{1'b1, 1'b1, 12'h07F, 12'h012, 16'd130},  // R4
        '{1'b0, 1'b0, 12'h015, 12'h012, 16'd24},   // R6
        '{1'b1, 1'b0, 12'h015, 12'h012, 16'd24},   // R6
        '{1'b0, 1'b0, 12'h015, 12'h112, 16'd280},  // R6
        '{1'b1, 1'b0, 12'h015, 12'h112, 16'd24},   // R6
        '{1'b1, 1'b0, 12'h015, 12'h1FF, 16'd261},  // R6
        '{1'b0, 1'b0, 12'h015, 12'h000, 16'd6}     // R6
    };

    initial begin
        int n;
        int ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 permit after reset", int'(tx_permit), 1);

        // R1: default registers
        duplex_full = 1'b0;
        run_gap(1'b1, 0, 0, 0, 0, 12'h0, 0, n);
        check("R1 default b2b half", n, 27);
        duplex_full = 1'b1;
        run_gap(1'b1, 0, 0, 0, 0, 12'h0, 0, n);
        check("R1 default b2b full", n, 24);
        run_gap(1'b0, 0, 0, 0, 0, 12'h0, 0, n);
        check("R1 default nb full", n, 24);

        // R3 R4 R6 R2: table walk
        foreach (VECS[k]) begin
            wr(1'b0, VECS[k].b2b_val);
            wr(1'b1, VECS[k].nb_val);
            duplex_full = VECS[k].full;
            run_gap(VECS[k].b2b, 0, 0, 0, 0, 12'h0, 0, n);
            check($sformatf("R2 vector %0d gap length", k), n, int'(VECS[k].exp));
        end

        // R2: permit low while transmitting
        @(negedge clk);
        while (!tx_permit) @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2 permit during frame", int'(tx_permit), 0);
        tx_en = 1'b0;
        repeat (300) @(negedge clk);

        // R5: late request keeps idle-start length
        wr(1'b0, 12'h040);
        wr(1'b1, 12'h012);
        duplex_full = 1'b0;
        run_gap(1'b0, 0, 0, 0, 0, 12'h0, 5, n);
        check("R5 late request stays nb", n, 24);

        // R7: carrier restarts half-duplex idle-start gap
        run_gap(1'b0, 10, 5, 0, 0, 12'h0, 0, n);
        check("R7 crs mid gap", n, 38);
        run_gap(1'b0, 1, 3, 0, 0, 12'h0, 0, n);
        check("R7 crs on first idle nibble", n, 27);

        // R8: carrier ignored in full duplex and in b2b gaps
        duplex_full = 1'b1;
        run_gap(1'b0, 10, 5, 0, 0, 12'h0, 0, n);
        check("R8 crs full duplex", n, 24);
        duplex_full = 1'b0;
        run_gap(1'b1, 10, 5, 0, 0, 12'h0, 0, n);
        check("R8 crs b2b half", n, 70);

        // R9: writes and duplex flips apply from the next gap
        run_gap(1'b1, 0, 0, 5, 1, 12'h010, 0, n);
        check("R9 write during gap", n, 70);
        run_gap(1'b1, 0, 0, 0, 0, 12'h0, 0, n);
        check("R9 next gap new value", n, 22);
        run_gap(1'b1, 0, 0, 5, 3, 12'h0, 0, n);
        check("R9 duplex flip during gap", n, 22);
        run_gap(1'b1, 0, 0, 0, 0, 12'h0, 0, n);
        check("R9 next gap full bias", n, 19);
        run_gap(1'b0, 0, 0, 4, 2, 12'h030, 0, n);
        check("R9 nb write during gap", n, 24);

        // R10: idle permit ignores request and carrier
        duplex_full = 1'b0;
        ok = 1;
        for (int i = 0; i < 20; i++) begin
            frame_req = i[0];
            crs = 1'b1;
            @(negedge clk);
            if (!tx_permit) ok = 0;
        end
        frame_req = 1'b0; crs = 1'b0;
        check("R10 idle permit held", ok, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule